// File: doc/BRIEF.md
# Configuration Boot Sequence Arbiter

This controller takes a programmable device from power-on to a configured state. When power is not yet good, it holds every user I/O in high impedance. Once power is good, it clears configuration memory for a fixed number of cycles. It then chooses how the device will be configured. The hold pin (active-low) lets an external host keep the device in initialization. While the pin is low and a timing window measured from power-good is still open, a slave port detector can claim the device. The arbiter then selects slave configuration.

If no slave claim arrives before the pin is released, the arbiter starts a master boot. It tries internal non-volatile memory first. If that memory reports that it is blank, the arbiter starts the external SPI flash engine instead. The done output goes high only after the chosen source reports success. If the flash also fails, the arbiter stops in an error state. A rising edge on the hold pin or a refresh strobe, arriving after initialization, restarts the sequence into master boot with the slave window closed. Losing power-good returns the block to its power-on state from anywhere.

All inputs are assumed to be synchronous to `clk`. The arbiter does not read the flash itself, does not parse the bitstream and does not sense power. It only sequences the engines that do those jobs.

Top module: `cfg_boot_arbiter`

## Requirements
- R1: While `por_ok_i` is low, on the next cycle `io_hiz_o`=1 and `done_o`, `clr_req_o`, `nvm_start_o`, `xfl_start_o` and `slv_sel_o` are all 0.
- R2: After `por_ok_i` rises, `clr_req_o` is high for exactly CLR_CYCLES consecutive cycles, and no start strobe or slave select is asserted during that time.
- R3: After the clear, if the hold pin stays low and no slave claim was accepted, the block waits with no start strobe and no slave select.
- R4: A `slave_act_i` pulse is accepted when the hold pin is low, the window is open and the block is clearing or initializing. The window covers the first WIN_CYCLES cycles after leaving the power-on state. An accepted claim raises `slv_sel_o` once the clear is complete, and no master start follows.
- R5: A `slave_act_i` pulse that arrives after the window has expired is ignored. Releasing the pin then starts master boot.
- R6: A `slave_act_i` pulse that arrives while the hold pin is high is ignored.
- R7: The hold pin being high in initialization, with no claim accepted, produces a one-cycle `nvm_start_o` pulse.
- R8: `nvm_ok_i` during the memory boot sets `done_o`=1 and `io_hiz_o`=0 on the next cycle. `io_hiz_o` is always the inverse of `done_o`.
- R9: `nvm_blank_i` during the memory boot produces a one-cycle `xfl_start_o` pulse on the next cycle. A following `xfl_ok_i` sets `done_o`.
- R10: `xfl_fail_i` after the fallback puts the block in an error state. `done_o` stays 0 and no further strobes occur until a restart.
- R11: In the done or error state, a refresh strobe or a rising edge on the hold pin restarts the clear and then a master boot. Slave claims are refused until the next power-on.
- R12: `slv_ok_i` in slave mode sets `done_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Power-on condition met |
| cfg_hold_n_i | input | 1 | Hold pin, low postpones master boot |
| refresh_i | input | 1 | Refresh command strobe |
| slave_act_i | input | 1 | Slave port declared active |
| nvm_ok_i | input | 1 | Internal memory boot succeeded |
| nvm_blank_i | input | 1 | Internal memory is blank |
| xfl_ok_i | input | 1 | External flash boot succeeded |
| xfl_fail_i | input | 1 | External flash boot failed |
| slv_ok_i | input | 1 | Slave configuration completed |
| done_o | output | 1 | Configuration done |
| io_hiz_o | output | 1 | Hold user I/O in high impedance |
| clr_req_o | output | 1 | Memory clear in progress |
| nvm_start_o | output | 1 | Start strobe, internal memory engine |
| xfl_start_o | output | 1 | Start strobe, external flash engine |
| slv_sel_o | output | 1 | Slave configuration selected |

## Verification
Four input patterns exercise the choice between slave and master boot, and each one separates a different condition of the acceptance rule:
- A claim made during the clear checks that claims are latched early.
- A claim made during initialization checks that claims are accepted at that point.
- A claim made with the pin high checks the pin-level condition.
- A claim made after the window checks the timeout.

Master boot is tried with a good memory, with a blank memory followed by a good flash, and with a blank memory followed by a failing flash. These three runs separate the fallback order from the error end. Restarts by refresh and by a pin edge, each with a claim held active, confirm that the window stays closed. A loss of power-good confirms the return to high impedance.

// File: rtl/cba_pkg.sv
package cba_pkg;

  typedef enum logic [3:0] {
    ST_POR      = 4'd0,
    ST_CLEAR    = 4'd1,
    ST_INIT     = 4'd2,
    ST_SLAVE    = 4'd3,
    ST_NVM_GO   = 4'd4,
    ST_NVM_WAIT = 4'd5,
    ST_XFL_GO   = 4'd6,
    ST_XFL_WAIT = 4'd7,
    ST_DONE     = 4'd8,
    ST_ERROR    = 4'd9
  } cba_state_e;

  // States in which a refresh or a pin edge restarts the sequence
  function automatic logic restartable(input cba_state_e s);
    return (s == ST_SLAVE)   || (s == ST_NVM_GO) || (s == ST_NVM_WAIT) ||
           (s == ST_XFL_GO)  || (s == ST_XFL_WAIT) ||
           (s == ST_DONE)    || (s == ST_ERROR);
  endfunction

endpackage

// File: rtl/cba_cycle_timer.sv
// Saturating up-counter; hit_o is high once LIMIT has been reached.
module cba_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  assign hit_o = (cnt_q == LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)               cnt_d = '0;
    else if (en_i && !hit_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cba_edge_det.sv
// Registers the hold pin level and flags its low-to-high transition.
module cba_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i && !lvl_q;
endmodule

// File: rtl/cba_seq.sv
// Boot sequencing state machine with slave-claim latch and window lockout.
module cba_seq
  import cba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok_i,
  input  logic       hold_n_i,
  input  logic       hold_rise_i,
  input  logic       refresh_i,
  input  logic       slave_act_i,
  input  logic       nvm_ok_i,
  input  logic       nvm_blank_i,
  input  logic       xfl_ok_i,
  input  logic       xfl_fail_i,
  input  logic       slv_ok_i,
  input  logic       clr_hit_i,
  input  logic       win_hit_i,
  output cba_state_e state_o
);
  cba_state_e st_q, st_d;
  logic       seen_q, seen_d;     // slave claim accepted
  logic       closed_q, closed_d; // window forced shut by a restart
  logic       win_open;
  logic       accept;
  logic       restart;

  assign win_open = !win_hit_i && !closed_q;
  assign accept   = slave_act_i && !hold_n_i && win_open &&
                    ((st_q == ST_CLEAR) || (st_q == ST_INIT));
  assign restart  = restartable(st_q) && (hold_rise_i || refresh_i);

  always_comb begin
    st_d     = st_q;
    seen_d   = seen_q;
    closed_d = closed_q;
    case (st_q)
      ST_POR: begin
        st_d     = ST_CLEAR;
        seen_d   = 1'b0;
        closed_d = 1'b0;
      end
      ST_CLEAR:    if (clr_hit_i) st_d = ST_INIT;
      ST_INIT: begin
        if (seen_q)        st_d = ST_SLAVE;
        else if (hold_n_i) st_d = ST_NVM_GO;
      end
      ST_SLAVE:    if (slv_ok_i) st_d = ST_DONE;
      ST_NVM_GO:   st_d = ST_NVM_WAIT;
      ST_NVM_WAIT: begin
        if (nvm_ok_i)         st_d = ST_DONE;
        else if (nvm_blank_i) st_d = ST_XFL_GO;
      end
      ST_XFL_GO:   st_d = ST_XFL_WAIT;
      ST_XFL_WAIT: begin
        if (xfl_ok_i)        st_d = ST_DONE;
        else if (xfl_fail_i) st_d = ST_ERROR;
      end
      ST_DONE:     st_d = ST_DONE;
      ST_ERROR:    st_d = ST_ERROR;
      default:     st_d = ST_POR;
    endcase
    if (accept) seen_d = 1'b1;
    if (restart) begin
      st_d     = ST_CLEAR;
      seen_d   = 1'b0;
      closed_d = 1'b1;
    end
    if (!por_ok_i) begin
      st_d     = ST_POR;
      seen_d   = 1'b0;
      closed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_POR;
      seen_q   <= 1'b0;
      closed_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      seen_q   <= seen_d;
      closed_q <= closed_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/cfg_boot_arbiter.sv
module cfg_boot_arbiter
  import cba_pkg::*;
#(
  parameter int CLR_CYCLES = 4096,
  parameter int WIN_CYCLES = 1900000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok_i,
  input  logic cfg_hold_n_i,
  input  logic refresh_i,
  input  logic slave_act_i,
  input  logic nvm_ok_i,
  input  logic nvm_blank_i,
  input  logic xfl_ok_i,
  input  logic xfl_fail_i,
  input  logic slv_ok_i,
  output logic done_o,
  output logic io_hiz_o,
  output logic clr_req_o,
  output logic nvm_start_o,
  output logic xfl_start_o,
  output logic slv_sel_o
);
  localparam int CLR_LIMIT = (CLR_CYCLES > 1) ? CLR_CYCLES - 1 : 0;

  cba_state_e state;
  logic       hold_rise;
  logic       clr_hit;
  logic       win_hit;

  cba_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (cfg_hold_n_i),
    .rise_o (hold_rise)
  );

  cba_cycle_timer #(.LIMIT(CLR_LIMIT)) u_clr_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (state != ST_CLEAR),
    .en_i  (1'b1),
    .hit_o (clr_hit)
  );

  cba_cycle_timer #(.LIMIT(WIN_CYCLES)) u_win_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (state == ST_POR),
    .en_i  (1'b1),
    .hit_o (win_hit)
  );

  cba_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_ok_i    (por_ok_i),
    .hold_n_i    (cfg_hold_n_i),
    .hold_rise_i (hold_rise),
    .refresh_i   (refresh_i),
    .slave_act_i (slave_act_i),
    .nvm_ok_i    (nvm_ok_i),
    .nvm_blank_i (nvm_blank_i),
    .xfl_ok_i    (xfl_ok_i),
    .xfl_fail_i  (xfl_fail_i),
    .slv_ok_i    (slv_ok_i),
    .clr_hit_i   (clr_hit),
    .win_hit_i   (win_hit),
    .state_o     (state)
  );

  always_comb begin
    done_o      = (state == ST_DONE);
    io_hiz_o    = (state != ST_DONE);
    clr_req_o   = (state == ST_CLEAR);
    nvm_start_o = (state == ST_NVM_GO);
    xfl_start_o = (state == ST_XFL_GO);
    slv_sel_o   = (state == ST_SLAVE);
  end
endmodule

// File: rtl/cba_checker.sv
module cba_checker (
  input logic clk,
  input logic rst_n,
  input logic por_ok_i,
  input logic nvm_ok_i,
  input logic nvm_blank_i,
  input logic xfl_ok_i,
  input logic slv_ok_i,
  input logic done_o,
  input logic io_hiz_o,
  input logic clr_req_o,
  input logic nvm_start_o,
  input logic xfl_start_o,
  input logic slv_sel_o
);
  p_por_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok_i |=> (io_hiz_o && !done_o && !clr_req_o &&
                   !nvm_start_o && !xfl_start_o && !slv_sel_o));

  p_clear_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req_o |-> !(nvm_start_o || xfl_start_o || slv_sel_o));

  p_nvm_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_start_o |=> !nvm_start_o);

  p_xfl_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfl_start_o |=> !xfl_start_o);

  p_xfl_after_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfl_start_o |-> $past(nvm_blank_i));

  p_done_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(nvm_ok_i || xfl_ok_i || slv_ok_i));
endmodule

bind cfg_boot_arbiter cba_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .por_ok_i    (por_ok_i),
  .nvm_ok_i    (nvm_ok_i),
  .nvm_blank_i (nvm_blank_i),
  .xfl_ok_i    (xfl_ok_i),
  .slv_ok_i    (slv_ok_i),
  .done_o      (done_o),
  .io_hiz_o    (io_hiz_o),
  .clr_req_o   (clr_req_o),
  .nvm_start_o (nvm_start_o),
  .xfl_start_o (xfl_start_o),
  .slv_sel_o   (slv_sel_o)
);

// File: tb/cfg_boot_arbiter_tb.sv
`timescale 1ns/1ps
module cfg_boot_arbiter_tb;
  localparam int CLR = 8;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic rst_n, por_ok, hold_n, refresh, slave_act;
  logic nvm_ok, nvm_blank, xfl_ok, xfl_fail, slv_ok;
  logic done, hiz, clr_req, nvm_start, xfl_start, slv_sel;
  int   n_chk = 0;
  int   n_bad = 0;

  always #2.5 clk = ~clk;

  cfg_boot_arbiter #(.CLR_CYCLES(CLR), .WIN_CYCLES(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_ok_i(por_ok), .cfg_hold_n_i(hold_n),
    .refresh_i(refresh), .slave_act_i(slave_act), .nvm_ok_i(nvm_ok),
    .nvm_blank_i(nvm_blank), .xfl_ok_i(xfl_ok), .xfl_fail_i(xfl_fail),
    .slv_ok_i(slv_ok), .done_o(done), .io_hiz_o(hiz), .clr_req_o(clr_req),
    .nvm_start_o(nvm_start), .xfl_start_o(xfl_start), .slv_sel_o(slv_sel)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {26'd0, done, hiz, clr_req, nvm_start, xfl_start, slv_sel};
  endfunction

  // Reset, then raise power-good and measure the clear; slv held during clear.
  task automatic power_up(input logic pin, input logic slv, input string req);
    int n;
    rst_n = 1'b0; por_ok = 1'b0; hold_n = 1'b0; refresh = 1'b0; slave_act = 1'b0;
    nvm_ok = 1'b0; nvm_blank = 1'b0; xfl_ok = 1'b0; xfl_fail = 1'b0; slv_ok = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: power not good -> only hiz set (bit 4 of outs)
    chk(outs() == 32'h10, "R1", outs(), 32'h10);
    por_ok = 1'b1; hold_n = pin; slave_act = slv;
    n = 0;
    tick();
    while (clr_req && n < 1000) begin
      if (nvm_start || xfl_start || slv_sel) chk(1'b0, "R2 quiet", 1, 0);
      n++;
      tick();
    end
    chk(n == CLR, req, n, CLR);
    slave_act = 1'b0;
  endtask

  task automatic t_slave_in_clear();
    power_up(1'b0, 1'b1, "R2 clear length");
    tick();
    chk(slv_sel && !nvm_start, "R4 claim during clear", slv_sel, 1);
    slv_ok = 1'b1; tick(); slv_ok = 1'b0;
    chk(done && !hiz, "R12 slave done", done, 1);
  endtask

  task automatic t_slave_in_init();
    power_up(1'b0, 1'b0, "R2 clear length");
    repeat (3) tick();
    chk(!slv_sel && !nvm_start, "R3 waiting", slv_sel, 0);
    slave_act = 1'b1; tick(); slave_act = 1'b0; tick();
    chk(slv_sel == 1'b1, "R4 claim during init", slv_sel, 1);
  endtask

  task automatic t_late_then_nvm();
    power_up(1'b0, 1'b0, "R2 clear length");
    repeat (WIN + 10) tick();
    chk(!nvm_start && !slv_sel && !done, "R3 waiting long", outs(), 32'h10);
    slave_act = 1'b1; tick(); slave_act = 1'b0; tick(); tick();
    chk(slv_sel == 1'b0, "R5 late claim ignored", slv_sel, 0);
    hold_n = 1'b1; tick();
    chk(nvm_start == 1'b1, "R5 release starts master", nvm_start, 1);
    tick();
    chk(nvm_start == 1'b0, "R7 pulse width", nvm_start, 0);
    nvm_ok = 1'b1; tick(); nvm_ok = 1'b0;
    chk(done && !hiz, "R8 memory done", done, 1);
    chk(!xfl_start, "R8 no fallback", xfl_start, 0);
    por_ok = 1'b0; tick();
    chk(outs() == 32'h10, "R1 power lost", outs(), 32'h10);
  endtask

  task automatic t_pin_high_claim();
    power_up(1'b1, 1'b1, "R2 clear length");
    tick();
    chk(nvm_start && !slv_sel, "R6 claim with pin high ignored", slv_sel, 0);
    tick();
    nvm_blank = 1'b1; tick(); nvm_blank = 1'b0;
    chk(xfl_start == 1'b1, "R9 fallback strobe", xfl_start, 1);
    tick();
    chk(xfl_start == 1'b0, "R9 pulse width", xfl_start, 0);
    xfl_ok = 1'b1; tick(); xfl_ok = 1'b0;
    chk(done == 1'b1, "R9 flash done", done, 1);
    // R11: pin edge restart with a claim held -> master boot again
    hold_n = 1'b0; slave_act = 1'b1; tick();
    chk(done == 1'b1, "R11 pin low no effect", done, 1);
    hold_n = 1'b1; tick(); tick();
    chk(clr_req == 1'b1, "R11 pin edge restarts clear", clr_req, 1);
    repeat (CLR) tick();
    chk(nvm_start && !slv_sel, "R11 master after edge", nvm_start, 1);
    slave_act = 1'b0;
  endtask

  task automatic t_error_refresh();
    power_up(1'b1, 1'b0, "R2 clear length");
    repeat (2) tick();
    nvm_blank = 1'b1; tick(); nvm_blank = 1'b0; tick();
    xfl_fail = 1'b1; tick(); xfl_fail = 1'b0;
    chk(!done && hiz, "R10 error keeps done low", done, 0);
    repeat (5) tick();
    chk(outs() == 32'h10, "R10 error quiet", outs(), 32'h10);
    hold_n = 1'b0; slave_act = 1'b1; refresh = 1'b1; tick(); refresh = 1'b0;
    chk(clr_req == 1'b1, "R11 refresh restarts clear", clr_req, 1);
    repeat (CLR + 4) tick();
    chk(!slv_sel && !nvm_start, "R11 window closed after restart", slv_sel, 0);
    slave_act = 1'b0; hold_n = 1'b1; tick();
    chk(nvm_start == 1'b1, "R11 master after refresh", nvm_start, 1);
  endtask

  initial begin
    t_slave_in_clear();
    t_slave_in_init();
    t_late_then_nvm();
    t_pin_high_claim();
    t_error_refresh();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule